// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is the management-side controller for a two-wire MDC/MDIO bus to a PHY. A host presents a PHY address, a register address, a read/write select and (for writes) a 16-bit value, then pulses `start`. The block makes MDC by dividing the system clock and shifts out a complete 64-bit management frame on MDIO. The frame is 32 synchronisation ones, a start code, an operation code, both addresses, a turnaround and a 16-bit data field.

On a write the block drives MDIO for the whole frame. On a read it stops driving MDIO at the first turnaround bit and samples the PHY on each rising MDC edge. The second turnaround bit must read as zero. The 16 data bits that follow are collected MSB first. When the frame ends, `done` pulses for one cycle and the result appears. `rd_data` holds the collected word, and `ta_err` flags a read whose second turnaround bit was not zero. Both stay unchanged until the next frame completes. MDIO is modelled as separate output, output-enable and input pins, and the pad and pull-up lie outside the block.

Top module: `mdio_master`

## Requirements
- R1: When no frame is in progress, `busy` is 0, `mdc` is held low and `mdio_oe` is 0. After reset, `done`, `ta_err` and `rd_data` are also 0.
- R2: Each frame opens with 32 MDC periods in which MDIO carries logic one.
- R3: The next four bits are the start code 0,1 and then the operation code: 1,0 for a read (`rd_nwr`=1) or 0,1 for a write.
- R4: The 5-bit PHY address and then the 5-bit register address follow the operation code, each sent MSB first.
- R5: On a write, the master drives 1 and then 0 as the two turnaround bits, followed by `wr_data` MSB first. `mdio_oe` stays 1 for all 64 bits.
- R6: On a read, `mdio_oe` is 1 for the first 46 bits and 0 from the first turnaround bit to the end of the frame.
- R7: The MDC period is 2×`HALF_DIV` system clocks. MDIO and `mdio_oe` change only together with a falling MDC edge, never at a rising one.
- R8: On a read, `rd_data` is the 16 values of `mdio_i` sampled at the MDC rising edges of bits 48..63, MSB first. It updates only in the cycle `done` is high.
- R9: `ta_err` is 1 at `done` exactly when the frame was a read and `mdio_i` sampled 1 at the second turnaround bit (bit 47). It changes only when `done` is high.
- R10: A frame is accepted on a clock edge where `start`=1 and `busy`=0. `busy` is 1 from the next cycle. `done` is a one-cycle pulse that rises 128×`HALF_DIV` clocks after the accepting edge, with `busy` falling at the same edge.
- R11: `start` is ignored while `busy` is 1. The frame in flight is unchanged, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a frame (accepted when idle) |
| rd_nwr | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | PHY address field |
| reg_addr | input | 5 | Register address field |
| wr_data | input | 16 | Data for a write frame |
| rd_data | output | 16 | Data gathered by the last read |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| ta_err | output | 1 | Last read saw a non-zero second turnaround bit |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
After an accepting edge, `busy` is due one cycle later. `done`, `rd_data` and `ta_err` are due exactly 128×`HALF_DIV` cycles later, and MDC rises follow one another every 2×`HALF_DIV` cycles. The bench drives inputs and reads outputs on the falling system-clock edge. It counts cycles from the accepting edge and requires `done` at exactly the computed count, then reads the result in that same sample. A PHY model driven from the MDC edges captures every bit and every enable value at each MDC rise. The bench compares these against frames it computes from the request fields, across a sweep of addresses, data, directions and turnaround values.

// File: rtl/mdio_pkg.sv
// Package: shared frame geometry and helpers for the MDIO master.
// Assumes clause-22 style frames of fixed 64-bit length.
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int ADDR_BITS  = 5;
    localparam int DATA_BITS  = 16;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = 46;   // first turnaround bit
    localparam int DATA_IDX   = 48;   // first data bit

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } mdio_opc_e;

    // Assemble the outgoing bit stream, first bit in the MSB.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic                 rd,
        input logic [ADDR_BITS-1:0] pa,
        input logic [ADDR_BITS-1:0] ra,
        input logic [DATA_BITS-1:0] wd
    );
        logic [1:0] opc;
        logic [1:0] ta;
        logic [DATA_BITS-1:0] dat;
        opc = rd ? 2'(OPC_READ) : 2'(OPC_WRITE);
        ta  = rd ? 2'b11 : 2'b10;
        dat = rd ? {DATA_BITS{1'b1}} : wd;
        return {{PRE_BITS{1'b1}}, 2'b01, opc, pa, ra, ta, dat};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
// Module: MDC generator. Runs only while a frame is active; MDC idles low.
// Gives one-cycle strobes on the system-clock edge that raises or lowers MDC.
// Assumes HALF_DIV >= 2.
module mdio_clkgen #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    // Half-period counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Edge strobes for the frame logic.
    always_comb begin
        rise_stb = run && (cnt == LAST) && !mdc;
        fall_stb = run && (cnt == LAST) &&  mdc;
    end
endmodule

// File: rtl/mdio_tx.sv
// Module: frame transmitter. Loads the whole frame and shifts it out one
// bit per MDC fall. Drops the output enable at the read turnaround or at
// the end of the frame. Assumes bit_idx is the index of the bit on the line.
module mdio_tx
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  shift,
    input  logic                  is_read,
    input  logic [IDX_W-1:0]      bit_idx,
    output logic                  mdio_o,
    output logic                  mdio_oe
);
    localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(TA_IDX - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] sr;

    // Shift register and driver enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr      <= '1;
            mdio_oe <= 1'b0;
        end else if (load) begin
            sr      <= frame;
            mdio_oe <= 1'b1;
        end else if (shift) begin
            sr <= {sr[FRAME_BITS-2:0], 1'b1};
            if (bit_idx == LAST_IDX || (is_read && bit_idx == REL_IDX))
                mdio_oe <= 1'b0;
        end
    end

    // Current bit is always the MSB.
    always_comb mdio_o = sr[FRAME_BITS-1];
endmodule

// File: rtl/mdio_rx.sv
// Module: read capture. Samples MDIO at MDC rises during a read. It checks
// the second turnaround bit and gathers the data MSB first. The results are
// published only at frame end.
module mdio_rx
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample,
    input  logic                 finish,
    input  logic                 is_read,
    input  logic [IDX_W-1:0]     bit_idx,
    input  logic                 mdio_i,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 ta_err
);
    localparam logic [IDX_W-1:0] TA2_IDX = IDX_W'(TA_IDX + 1);
    localparam logic [IDX_W-1:0] D0_IDX  = IDX_W'(DATA_IDX);

    logic [DATA_BITS-1:0] sh;
    logic                 ta_bad;

    // Bit capture during the read tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            ta_bad <= 1'b0;
        end else if (sample && is_read) begin
            if (bit_idx == TA2_IDX)
                ta_bad <= mdio_i;
            if (bit_idx >= D0_IDX)
                sh <= {sh[DATA_BITS-2:0], mdio_i};
        end
    end

    // Result publication at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            ta_err  <= 1'b0;
        end else if (finish) begin
            if (is_read)
                rd_data <= sh;
            ta_err <= is_read && ta_bad;
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Module: MDIO management master top. It accepts one request at a time,
// runs the 64-bit frame and reports the result with a done pulse.
// Assumes the external pad resolves mdio_o/mdio_oe with a pull-up.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 rd_nwr,
    input  logic [ADDR_BITS-1:0] phy_addr,
    input  logic [ADDR_BITS-1:0] reg_addr,
    input  logic [DATA_BITS-1:0] wr_data,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 busy,
    output logic                 done,
    output logic                 ta_err,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic             accept;
    logic             rise_stb;
    logic             fall_stb;
    logic             is_read;
    logic             finish;
    logic [IDX_W-1:0] bit_idx;

    // Request acceptance and end-of-frame detection.
    always_comb begin
        accept = start && !busy;
        finish = fall_stb && (bit_idx == LAST_IDX);
    end

    // Frame sequencer: busy flag, bit index, direction, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            is_read <= 1'b0;
            bit_idx <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                is_read <= rd_nwr;
                bit_idx <= '0;
            end else if (finish) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (fall_stb) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .frame   (build_frame(rd_nwr, phy_addr, reg_addr, wr_data)),
        .shift   (fall_stb),
        .is_read (is_read),
        .bit_idx (bit_idx),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    mdio_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (rise_stb),
        .finish  (finish),
        .is_read (is_read),
        .bit_idx (bit_idx),
        .mdio_i  (mdio_i),
        .rd_data (rd_data),
        .ta_err  (ta_err)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Module: protocol checker for mdio_master, attached by bind below.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        ta_err,
    input logic [15:0] rd_data,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

    // R7
    rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R10
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R11
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rd_data));

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ta_err));
endmodule

bind mdio_master mdio_master_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .ta_err  (ta_err),
    .rd_data (rd_data),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/test_mdio_master.sv
// Bench: sweeps write and read frames through mdio_master against a PHY model.
module test_mdio_master;
    localparam int HD = 2;
    localparam int FRAME_CYC = 128 * HD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        busy, done, ta_err, mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    logic        phy_oe = 1'b0;
    logic        phy_val = 1'b1;
    logic        cur_rd = 1'b0;
    logic        ta_drive = 1'b0;
    logic [15:0] phy_data = '0;
    logic [63:0] cap, oecap;
    int          rcnt = 0;
    int          contention = 0;
    int          cyc = 0;
    int          r0 = 0, r1 = 0;
    int          n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_val : 1'b1);

    mdio_master #(.HALF_DIV(HD)) i_mdio_master (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .done(done), .ta_err(ta_err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always @(posedge clk) cyc++;

    // PHY model: captures the line at each MDC rise.
    always @(posedge mdc) begin
        if (rcnt < 64) begin
            cap   = {cap[62:0], mdio_i};
            oecap = {oecap[62:0], mdio_oe};
        end
        if (mdio_oe && phy_oe) contention++;
        if (rcnt == 0) r0 = cyc;
        if (rcnt == 1) r1 = cyc;
        rcnt++;
    end

    // PHY model: drives its read response on MDC falls.
    always @(negedge mdc) begin
        if (cur_rd && rcnt == 47) begin
            phy_oe  = 1'b1;
            phy_val = ta_drive;
        end else if (cur_rd && rcnt >= 48 && rcnt <= 63) begin
            phy_oe  = 1'b1;
            phy_val = phy_data[63 - rcnt];
        end else begin
            phy_oe = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] pd,
                             input logic tad, input logic interfere);
        int k;
        logic [63:0] exp_f, exp_oe;
        logic [15:0] prev_rd;
        @(negedge clk);
        prev_rd  = rd_data;
        rcnt     = 0;
        cur_rd   = rd;
        phy_data = pd;
        ta_drive = tad;
        contention = 0;
        rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy after accept", 64'(busy), 64'd1);
        k = 0;
        do begin
            if (interfere && k == 40) begin
                start = 1'b1; rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            k++;
        end while (!done && k < 4 * FRAME_CYC);
        start = 1'b0;
        chk("R10 done latency", 64'(k), 64'(FRAME_CYC));
        chk("R10 busy low at done", 64'(busy), 64'd0);
        exp_f  = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra,
                  rd ? {1'b1, tad} : 2'b10, rd ? pd : wd};
        exp_oe = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
        chk("R2 preamble", 64'(cap[63:32]), 64'(exp_f[63:32]));
        chk("R3 start/op", 64'(cap[31:28]), 64'(exp_f[31:28]));
        chk("R4 addresses", 64'(cap[27:18]), 64'(exp_f[27:18]));
        if (rd) begin
            chk("R6 read enable pattern", oecap, exp_oe);
            chk("R8 rd_data", 64'(rd_data), 64'(pd));
        end else begin
            chk("R5 write turnaround/data", 64'(cap[17:0]), 64'(exp_f[17:0]));
            chk("R5 write enable pattern", oecap, exp_oe);
            chk("R8 rd_data held on write", 64'(rd_data), 64'(prev_rd));
        end
        chk("R9 ta_err", 64'(ta_err), 64'(rd & tad));
        chk("R7 mdc period", 64'(r1 - r0), 64'(2 * HD));
        chk("R6 no contention", 64'(contention), 64'd0);
        chk("R11 one frame only", 64'(rcnt), 64'd64);
        @(negedge clk);
        chk("R10 done single pulse", 64'(done), 64'd0);
        chk("R1 idle enable/clock", {62'd0, mdio_oe, mdc}, 64'd0);
        if (interfere) begin
            for (int w = 0; w < 4 * FRAME_CYC; w++) begin
                @(negedge clk);
                if (busy) break;
            end
            chk("R11 no second frame", 64'(busy), 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", {40'd0, rd_data, busy, done, ta_err, mdc, mdio_oe, 3'd0},
            64'd0);
        for (int i = 0; i < 12; i++)
            run_frame(1'b0, 5'(i * 3 + 1), 5'(31 - i * 2), 16'(16'h8001 ^ (i * 16'h1357)),
                      16'h0, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++)
            run_frame(1'b1, 5'(i * 5), 5'(i * 7 + 2), 16'h0,
                      16'(16'hA5C3 ^ (i * 16'h2469)), 1'b0, 1'b0);
        run_frame(1'b1, 5'h1F, 5'h00, 16'h0, 16'hFFFF, 1'b1, 1'b0);
        run_frame(1'b1, 5'h00, 5'h1F, 16'h0, 16'h0000, 1'b1, 1'b0);
        run_frame(1'b1, 5'h15, 5'h0A, 16'h0, 16'h8000, 1'b0, 1'b0);
        run_frame(1'b0, 5'h0A, 5'h15, 16'h0001, 16'h0, 1'b0, 1'b1);
        run_frame(1'b1, 5'h11, 5'h0E, 16'h0, 16'h7FFE, 1'b0, 1'b1);
        summary();
    end
endmodule